// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular list of transmit buffer descriptors kept in a small word-addressed memory and hands each ready buffer to a DMA engine. Software fills descriptors and sets their ready flag, then writes a doorbell. The walker reads each descriptor in ring order and offers the buffer pointer and length to the DMA port on a valid/ready handshake. It waits for the DMA's done pulse and then writes the first descriptor word back with the ready flag cleared, which returns the buffer to software.

When the walker reads a descriptor that is not ready, it reads it once more before it gives up. If the flag is still clear on that second read, it stops and leaves the ring position on that descriptor. A doorbell that arrives while the walker is busy is remembered. In that case the walker runs a fresh pair of polls on the current descriptor instead of stopping.

Each descriptor is two 32-bit words. Word 0 holds the flags in bits [15:0] and the byte length in bits [31:16]. The flags are: bit 0 ready, bit 1 wrap, bit 2 last. Word 1 holds the buffer pointer. The DMA port follows stream rules. Once `dma_valid_o` is raised, the pointer, length and last outputs hold steady until a cycle in which `dma_ready_i` is high, and the transfer is taken in that cycle. `dma_ready_i` may stay low for any number of cycles. The descriptor memory returns read data on the cycle after the request.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset, `idle_o` is 1 and neither `mem_req_o` nor `dma_valid_o` is asserted until a doorbell arrives.
- R2: A one-cycle pulse on `kick_i` while idle starts processing, and the value on `kick_data_i` has no effect on the outcome.
- R3: Ready descriptors are processed strictly in ring order. For each one, the DMA port presents word 1 as the pointer, bits [31:16] of word 0 as the length, and flag bit 2 as the last flag.
- R4: While `dma_valid_o` is 1 and `dma_ready_i` is 0, the next cycle still has `dma_valid_o` at 1 with pointer and length unchanged.
- R5: After `dma_done_i`, word 0 of that descriptor is written back with bit 0 cleared and every other bit unchanged, and no memory write ever sets bit 0.
- R6: A descriptor read with bit 0 clear is read a second time at the same address. If bit 0 is clear again, the walker goes idle and makes no further memory or DMA request until the next doorbell.
- R7: If bit 0 is set on the second read, that descriptor is transferred normally.
- R8: After a write-back, the next descriptor address is the ring base if flag bit 1 was set, and otherwise the current address plus 2 words.
- R9: A doorbell received while busy is remembered. At the stop decision it causes one more pair of polls of the same descriptor instead of idling.
- R10: The first doorbell after reset starts at `ring_base_i`. Later doorbells resume at the descriptor where the walker stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | Doorbell write strobe |
| kick_data_i | input | 32 | Doorbell write data (ignored) |
| ring_base_i | input | AW | Word address of descriptor 0 |
| mem_req_o | output | 1 | Descriptor memory access |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after request |
| dma_valid_o | output | 1 | Buffer transfer request valid |
| dma_ready_i | input | 1 | DMA accepts the request |
| dma_ptr_o | output | 32 | Buffer pointer |
| dma_len_o | output | 16 | Buffer length in bytes |
| dma_last_o | output | 1 | Buffer ends a frame |
| dma_done_i | input | 1 | Transfer complete pulse |
| idle_o | output | 1 | Walker is stopped |

## Verification
A doorbell can land in the same stretch of activity as the stop decision: the walker is busy with a transfer, or is polling a descriptor that is not ready, when software rings again. The bench provokes this by holding the DMA port stalled and pulsing the doorbell during the transfer of a ready descriptor whose successor is not ready. The correct result is four reads of the successor's word 0 instead of two, followed by idle. A second overlap, software setting the ready flag between the two polls, is produced by the memory model flipping the flag right after the first read is served. That case must yield a transfer of that descriptor.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int DESC_WDS = 2;
  localparam int F_READY  = 0;
  localparam int F_WRAP   = 1;
  localparam int F_LAST   = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_W0, S_RD1, S_W1, S_REQ, S_WAIT, S_WB
  } walk_st_e;
endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  input  logic          advance_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] word1_o
);
  import txd_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(DESC_WDS);

  logic [AW-1:0] cur_q;
  logic          primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      primed_q <= 1'b0;
    end else if (load_i && !primed_q) begin
      cur_q    <= base_i;
      primed_q <= 1'b1;
    end else if (advance_i) begin
      cur_q <= wrap_i ? base_i : cur_q + STEP;
    end
  end

  assign cur_o   = cur_q;
  assign word1_o = cur_q + AW'(1);

  a_r8_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && wrap_i && primed_q) |=> (cur_o == $past(base_i)));
  a_r8_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !wrap_i && primed_q) |=> (cur_o == $past(cur_o) + STEP));
endmodule

// File: rtl/txd_doorbell.sv
module txd_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic busy_i,
  input  logic consume_i,
  output logic pending_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         pend_q <= 1'b0;
    else if (consume_i)                 pend_q <= 1'b0;
    else if (kick_i && busy_i)          pend_q <= 1'b1;
  end

  assign pending_o = pend_q;

  a_r9_kick_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && busy_i && !consume_i) |=> pending_o);
  a_r9_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !pending_o);
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker #(
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      kick_i,
  input  logic [31:0]               kick_data_i,
  input  logic [AW-1:0]             ring_base_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [31:0]               mem_wdata_o,
  input  logic [31:0]               mem_rdata_i,
  output logic                      dma_valid_o,
  input  logic                      dma_ready_i,
  output logic [31:0]               dma_ptr_o,
  output logic [15:0]               dma_len_o,
  output logic                      dma_last_o,
  input  logic                      dma_done_i,
  output logic                      idle_o
);
  import txd_pkg::*;

  walk_st_e            st_q, st_d;
  logic                second_q, second_d;
  logic [WORD_W-1:0]   w0_q, w1_q;
  logic [AW-1:0]       cur, cur_w1;
  logic                pending, consume, busy, kick_any, rd_ready;
  logic                advance;
  logic                unused_kick_data;

  assign unused_kick_data = ^kick_data_i;
  assign busy     = (st_q != S_IDLE);
  assign kick_any = kick_i | pending;
  assign rd_ready = mem_rdata_i[F_READY];
  assign consume  = (st_q == S_W0) && !rd_ready && second_q && kick_any;
  assign advance  = (st_q == S_WB);

  txd_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_i(ring_base_i),
    .load_i(st_q == S_IDLE && kick_i), .advance_i(advance),
    .wrap_i(w0_q[F_WRAP]), .cur_o(cur), .word1_o(cur_w1)
  );

  txd_doorbell u_bell (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .busy_i(busy),
    .consume_i(consume), .pending_o(pending)
  );

  always_comb begin
    st_d     = st_q;
    second_d = second_q;
    unique case (st_q)
      S_IDLE: if (kick_i) begin st_d = S_RD0; second_d = 1'b0; end
      S_RD0:  st_d = S_W0;
      S_W0: begin
        if (rd_ready) begin
          st_d = S_RD1; second_d = 1'b0;
        end else if (!second_q) begin
          st_d = S_RD0; second_d = 1'b1;
        end else if (kick_any) begin
          st_d = S_RD0; second_d = 1'b0;
        end else begin
          st_d = S_IDLE; second_d = 1'b0;
        end
      end
      S_RD1:  st_d = S_W1;
      S_W1:   st_d = S_REQ;
      S_REQ:  if (dma_ready_i) st_d = S_WAIT;
      S_WAIT: if (dma_done_i) st_d = S_WB;
      S_WB:   st_d = S_RD0;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      second_q <= 1'b0;
      w0_q     <= '0;
      w1_q     <= '0;
    end else begin
      st_q     <= st_d;
      second_q <= second_d;
      if (st_q == S_W0) w0_q <= mem_rdata_i;
      if (st_q == S_W1) w1_q <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur;
    mem_wdata_o = w0_q;
    mem_wdata_o[F_READY] = 1'b0;
    case (st_q)
      S_RD0: mem_req_o = 1'b1;
      S_RD1: begin mem_req_o = 1'b1; mem_addr_o = cur_w1; end
      S_WB:  begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end

  assign dma_valid_o = (st_q == S_REQ);
  assign dma_ptr_o   = w1_q;
  assign dma_len_o   = w0_q[WORD_W-1 -: LEN_W];
  assign dma_last_o  = w0_q[F_LAST];
  assign idle_o      = !busy;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!mem_req_o && !dma_valid_o));
  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid_o && !dma_ready_i) |=>
      (dma_valid_o && $stable(dma_ptr_o) && $stable(dma_len_o)));
  a_r5_wb_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[F_READY]);
  a_r6_repoll_same: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_W0 && !rd_ready && !second_q) |=>
      (mem_req_o && !mem_we_o && mem_addr_o == $past(cur)));
  a_r5_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> $past(dma_done_i));
endmodule

// File: tb/txd_ring_walker_bench.sv
module txd_ring_walker_bench;
  localparam int AW    = 8;
  localparam int BASE  = 8;
  localparam int NDESC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        kick = 1'b0;
  logic [31:0] kick_data = '0;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        dma_valid, dma_ready, dma_last, dma_done, idle;
  logic [31:0] dma_ptr;
  logic [15:0] dma_len;

  txd_ring_walker #(.AW(AW)) u_txd_ring_walker (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .kick_data_i(kick_data),
    .ring_base_i(AW'(BASE)), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dma_valid_o(dma_valid), .dma_ready_i(dma_ready), .dma_ptr_o(dma_ptr),
    .dma_len_o(dma_len), .dma_last_o(dma_last), .dma_done_i(dma_done),
    .idle_o(idle)
  );

  // memory model with backdoor and one-shot ready flip
  logic [31:0] mem [256];
  int          rd_cnt [256];
  int          acc_cnt;
  logic        bk_we = 1'b0;
  logic [7:0]  bk_addr = '0;
  logic [31:0] bk_data = '0;
  logic        clr = 1'b0;
  logic        flip_en = 1'b0;
  logic [7:0]  flip_addr = '0;

  always_ff @(posedge clk) begin
    if (bk_we) mem[bk_addr] <= bk_data;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr];
      if (flip_en && mem_addr == flip_addr && rd_cnt[mem_addr] == 0)
        mem[mem_addr][0] <= 1'b1;
    end
    if (clr) begin
      for (int i = 0; i < 256; i++) rd_cnt[i] <= 0;
      acc_cnt <= 0;
    end else if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (!mem_we) rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
    end
  end

  // DMA model
  int          stall_cfg = 0;
  int          wcnt, dcnt;
  int          dma_n, stab_err;
  logic [31:0] log_ptr [16];
  logic [15:0] log_len [16];
  logic        log_last [16];
  logic        pv;
  logic [31:0] pptr;
  logic [15:0] plen;

  assign dma_ready = dma_valid && (wcnt >= stall_cfg);
  assign dma_done  = (dcnt == 1);

  always_ff @(posedge clk) begin
    if (clr) begin
      wcnt <= 0; dcnt <= 0; dma_n <= 0; stab_err <= 0; pv <= 1'b0;
    end else begin
      pv   <= dma_valid && !dma_ready;
      pptr <= dma_ptr;
      plen <= dma_len;
      if (pv && (!dma_valid || dma_ptr != pptr || dma_len != plen))
        stab_err <= stab_err + 1;
      if (dma_valid && dma_ready) begin
        wcnt <= 0;
        dcnt <= 2;
        if (dma_n < 16) begin
          log_ptr[dma_n]  <= dma_ptr;
          log_len[dma_n]  <= dma_len;
          log_last[dma_n] <= dma_last;
        end
        dma_n <= dma_n + 1;
      end else begin
        if (dma_valid) wcnt <= wcnt + 1;
        if (dcnt != 0) dcnt <= dcnt - 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] d_word0(input int i, input bit rdy);
    logic [15:0] len;
    len = 16'h40 + 16'(i * 3);
    return {len, 13'b0, 1'(i % 2), 1'(i == NDESC - 1), rdy};
  endfunction
  function automatic logic [31:0] d_ptr(input int i);
    return 32'h1000_0000 + 32'(i * 'h100);
  endfunction

  task automatic bk_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bk_we = 1'b1; bk_addr = 8'(a); bk_data = d;
    @(negedge clk);
    bk_we = 1'b0;
  endtask

  task automatic fill_ring(input int nready);
    for (int i = 0; i < NDESC; i++) begin
      bk_write(BASE + 2*i, d_word0(i, i < nready));
      bk_write(BASE + 2*i + 1, d_ptr(i));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clr = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; clr = 1'b0;
  endtask

  task automatic clear_logs();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic ring(input logic [31:0] data);
    @(negedge clk);
    kick = 1'b1; kick_data = data;
    @(negedge clk);
    kick = 1'b0; kick_data = '0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (!idle && t < 2000) begin @(negedge clk); t++; end
    check(t < 2000, "R6 walker reaches idle", t, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int stop, acc0, base_n;
    do_reset();
    @(negedge clk);
    check(idle === 1'b1, "R1 idle after reset", idle, 1);
    check(mem_req === 1'b0 && dma_valid === 1'b0, "R1 quiet after reset", {mem_req, dma_valid}, 0);
    repeat (5) @(negedge clk);
    check(acc_cnt == 0, "R1 no access before doorbell", acc_cnt, 0);

    for (int nr = 0; nr <= NDESC; nr++) begin
      for (int st = 0; st < 3; st++) begin
        do_reset();
        stall_cfg = st;
        fill_ring(nr);
        clear_logs();
        ring(32'(nr * 'h1234567 + st * 'h89abcd));
        wait_idle();
        check(dma_n == nr, "R2/R3 transfer count", dma_n, nr);
        for (int i = 0; i < nr; i++) begin
          check(log_ptr[i] == d_ptr(i), "R3 pointer in ring order", log_ptr[i], d_ptr(i));
          check(log_len[i] == d_word0(i, 0)[31:16], "R3 length", log_len[i], d_word0(i, 0)[31:16]);
          check(log_last[i] == 1'(i % 2), "R3 last flag", log_last[i], i % 2);
          check(mem[BASE + 2*i] == d_word0(i, 0), "R5 write-back clears ready only",
                mem[BASE + 2*i], d_word0(i, 0));
        end
        check(stab_err == 0, "R4 offer held while stalled", stab_err, 0);
        stop = nr % NDESC;
        check(rd_cnt[BASE + 2*stop] == 2 + (nr == NDESC ? 1 : 0),
              "R6 R8 double poll at stop descriptor", rd_cnt[BASE + 2*stop], 2 + (nr == NDESC ? 1 : 0));
        acc0 = acc_cnt;
        repeat (20) @(negedge clk);
        check(acc_cnt == acc0 && idle, "R6 silent while idle", acc_cnt, acc0);
        // R10: resume at stop position
        base_n = dma_n;
        bk_write(BASE + 2*stop, d_word0(stop, 1));
        ring(32'hffff_ffff);
        wait_idle();
        check(dma_n == base_n + 1, "R10 one more transfer", dma_n, base_n + 1);
        check(log_ptr[base_n] == d_ptr(stop), "R10 resumes at stop descriptor",
              log_ptr[base_n], d_ptr(stop));
      end
    end

    // R7: ready flag appears between the two polls
    do_reset();
    stall_cfg = 0;
    fill_ring(0);
    clear_logs();
    @(negedge clk); flip_addr = 8'(BASE); flip_en = 1'b1;
    ring(32'h0);
    wait_idle();
    flip_en = 1'b0;
    check(dma_n == 1, "R7 second poll ready leads to transfer", dma_n, 1);
    check(log_ptr[0] == d_ptr(0), "R7 transferred descriptor 0", log_ptr[0], d_ptr(0));
    check(rd_cnt[BASE] == 2, "R7 descriptor 0 polled twice", rd_cnt[BASE], 2);
    check(rd_cnt[BASE + 2] == 2, "R7 then stops at descriptor 1", rd_cnt[BASE + 2], 2);

    // R9: doorbell during busy transfer
    do_reset();
    stall_cfg = 6;
    fill_ring(1);
    clear_logs();
    ring(32'h5a5a);
    repeat (4) @(negedge clk);
    check(!idle, "R9 busy when second doorbell rings", idle, 0);
    ring(32'ha5a5);
    wait_idle();
    check(dma_n == 1, "R9 single transfer", dma_n, 1);
    check(rd_cnt[BASE + 2] == 4, "R9 extra poll pair on stop descriptor", rd_cnt[BASE + 2], 4);
    check(stab_err == 0, "R4 offer held with long stall", stab_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule